// File: doc/BRIEF.md
# Serial Configuration Port with Shadowed Register File

This block is a slave serial port that gives a host access to a bank of 8-bit configuration registers. It uses three signals: a serial clock, an active-low select and one data line that turns around for reads. The bidirectional line appears here as separate input, output and output-enable signals. The serial signals are brought into the system clock domain through synchronizers and are then oversampled, so the serial clock has to run several times slower than `clk_i`.

Each frame begins with a 16-bit instruction word, followed by data bytes. The instruction word holds a read flag in bit 15 (1 = read), a byte-count code in bits 14:13 and a 13-bit register address in bits 12:0. The byte-count code selects one, two or three bytes, or an open-ended stream. Writes go into master registers. For most addresses the value driven on `cfg_o` is a separate active copy. That copy is updated from the masters only when the host sets the transfer bit. A few control addresses act immediately. A configuration register selects the bit order and requests a soft reset, and address 0x01 returns a fixed identifier.

Top module: `spi_regs_top`

## Requirements
- R1: While select is low, the data line is sampled on each rising serial-clock edge. The first 16 bits form the instruction: bit 15 is the read flag, bits 14:13 are the count code and bits 12:0 are the address. In MSB-first mode bit 15 is sent first.
- R2: Count codes 0, 1 and 2 move one, two and three data bytes. After the last byte the port is back in the instruction phase, and following bits in the same frame form a new instruction.
- R3: Count code 3 streams bytes until select goes high.
- R4: After each data byte the address steps down by one in MSB-first mode and up by one in LSB-first mode. It wraps within 13 bits.
- R5: During the data phase of a read, with select low, `sdio_oe_o` is high. `sdio_o` changes only after a falling serial-clock edge and carries the addressed register, MSB first (bit 7) or LSB first (bit 0) according to the mode.
- R6: If select rises inside the instruction or inside a data byte, the partial bits are discarded, nothing is written, and the next frame starts with a new instruction.
- R7: In a 1-, 2- or 3-byte transfer, select may rise and fall again between bytes, and the transfer then continues with the next byte. A rising clock edge that arrives together with the rise of select still completes its byte.
- R8: Writes to addresses 0x02, 0x04 and 0x05 reach `cfg_o` at once. Every other mapped register shows on `cfg_o` only its active copy, and a read returns the master value.
- R9: Writing a byte with bit 0 set to address 0xFF copies every master to its active copy in the next cycle. The bit clears itself after one cycle, so 0xFF then reads 0x00.
- R10: Address 0x01 always reads 0x13 and ignores writes.
- R11: After reset, address 0x00 reads 0x18, address 0x09 reads 0x01 and every other register reads 0x00. `cfg_o` holds the same values.
- R12: In address 0x00, LSB-first mode is requested by bit 6 or bit 1 and soft reset by bit 5 or bit 2. A read shows each setting in both of its positions, with bits 4:3 reading 1. A new bit order applies from the next instruction. Soft reset restores every default, including the active copies and the bit order, and then clears itself.
- R13: Addresses at or above NUM_REGS, other than 0xFF, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| csb_i | input | 1 | Frame select, active low |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data to the host |
| sdio_oe_o | output | 1 | Drive enable for the shared data line |
| cfg_o | output | NUM_REGS*8 | Active register values, register i in bits i*8+7:i*8 |

## Verification
Two events can land in the same system-clock cycle: the rising serial-clock edge that completes a byte and the rise of select. Both pass through equal synchronizer depths. The bench provokes the case by raising the clock and the select at the same instant on the last bit of a streamed write. The byte must still be written, which shows up on `cfg_o` for an immediate register, and the frame must then close. A second stream is cut three bits into its next byte, and a later readback must show that the partial byte reached no register.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 13'h000;
  localparam logic [ADDR_W-1:0] ID_ADDR   = 13'h001;
  localparam logic [ADDR_W-1:0] XFER_ADDR = 13'h0FF;
  localparam logic [7:0] CHIP_ID = 8'h13;

  typedef enum logic {PH_INSTR, PH_DATA} phase_e;
  typedef enum logic [1:0] {CNT_ONE, CNT_TWO, CNT_THREE, CNT_STREAM} count_e;

  function automatic logic is_direct(int idx);
    return (idx == 0) || (idx == 2) || (idx == 4) || (idx == 5);
  endfunction

  function automatic logic [7:0] reg_default(int idx);
    return (idx == 9) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/spi_regs_sync.sv
module spi_regs_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_regs_frame.sv
module spi_regs_frame
  import spi_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_n_s_i,
  input  logic              sdi_s_i,
  input  logic              lsb_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  phase_e            phase_q, phase_n;
  logic [3:0]        bit_q, bit_n;
  logic [15:0]       ish_q, ish_n, ish_nx;
  logic [7:0]        dsh_q, dsh_n, dsh_nx;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_step;
  logic              rnw_q, rnw_n, strm_q, strm_n, lsb_q, lsb_n;
  logic [1:0]        left_q, left_n;
  logic              sclk_d_q, cs_d_q;
  logic              sdo_q, sdo_n;
  logic              wr_q, wr_n;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              sclk_rise, sclk_fall, cs_rise, cs_open;
  logic [2:0]        oidx;

  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign sclk_fall = ~sclk_s_i & sclk_d_q;
  assign cs_rise   = cs_n_s_i & ~cs_d_q;
  // an edge that coincides with select rising still belongs to the frame
  assign cs_open   = ~cs_n_s_i | cs_rise;

  assign ish_nx    = lsb_q ? {sdi_s_i, ish_q[15:1]} : {ish_q[14:0], sdi_s_i};
  assign dsh_nx    = lsb_q ? {sdi_s_i, dsh_q[7:1]} : {dsh_q[6:0], sdi_s_i};
  assign addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
  assign oidx      = lsb_q ? bit_q[2:0] : ~bit_q[2:0];

  always_comb begin
    phase_n = phase_q;
    bit_n   = bit_q;
    ish_n   = ish_q;
    dsh_n   = dsh_q;
    addr_n  = addr_q;
    rnw_n   = rnw_q;
    strm_n  = strm_q;
    left_n  = left_q;
    lsb_n   = lsb_q;
    sdo_n   = sdo_q;
    wr_n    = 1'b0;

    if (sclk_rise && cs_open) begin
      bit_n = bit_q + 4'd1;
      if (phase_q == PH_INSTR) begin
        ish_n = ish_nx;
        if (bit_q == 4'd15) begin
          phase_n = PH_DATA;
          bit_n   = '0;
          rnw_n   = ish_nx[15];
          strm_n  = (count_e'(ish_nx[14:13]) == CNT_STREAM);
          left_n  = ish_nx[14:13];
          addr_n  = ish_nx[12:0];
        end
      end else begin
        dsh_n = dsh_nx;
        if (bit_q == 4'd7) begin
          bit_n  = '0;
          wr_n   = ~rnw_q;
          addr_n = addr_step;
          if (!strm_q && left_q == 2'd0) phase_n = PH_INSTR;
          else left_n = left_q - 2'd1;
        end
      end
    end

    if (cs_rise && !(phase_n == PH_DATA && bit_n == 4'd0 && !strm_n)) begin
      phase_n = PH_INSTR;
      bit_n   = '0;
    end

    // bit order is picked up only between instructions
    if (phase_q == PH_INSTR && bit_q == 4'd0) lsb_n = lsb_i;

    if (sclk_fall && !cs_n_s_i && phase_q == PH_DATA && rnw_q)
      sdo_n = rd_data_i[oidx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_INSTR;
      bit_q     <= '0;
      ish_q     <= '0;
      dsh_q     <= '0;
      addr_q    <= '0;
      rnw_q     <= 1'b0;
      strm_q    <= 1'b0;
      left_q    <= '0;
      lsb_q     <= 1'b0;
      sdo_q     <= 1'b0;
      sclk_d_q  <= 1'b0;
      cs_d_q    <= 1'b1;
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q  <= phase_n;
      bit_q    <= bit_n;
      ish_q    <= ish_n;
      dsh_q    <= dsh_n;
      addr_q   <= addr_n;
      rnw_q    <= rnw_n;
      strm_q   <= strm_n;
      left_q   <= left_n;
      lsb_q    <= lsb_n;
      sdo_q    <= sdo_n;
      sclk_d_q <= sclk_s_i;
      cs_d_q   <= cs_n_s_i;
      wr_q     <= wr_n;
      if (wr_n) begin
        wr_addr_q <= addr_q;
        wr_data_q <= dsh_nx;
      end
    end
  end

  assign addr_o    = addr_q;
  assign wr_o      = wr_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = (phase_q == PH_DATA) && rnw_q && !cs_n_s_i;
endmodule

// File: rtl/spi_regs_bank.sv
module spi_regs_bank
  import spi_regs_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic                  lsb_o,
  output logic                  xfer_o,
  output logic                  srst_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(NUM_REGS);

  logic       lsb_q, srst_q, xfer_q;
  logic [7:0] mst_w [NUM_REGS];
  logic [7:0] act_w [NUM_REGS];
  logic [7:0] cfg0_w;

  assign cfg0_w = {1'b0, lsb_q, srst_q, 2'b11, srst_q, lsb_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q  <= 1'b0;
      srst_q <= 1'b0;
      xfer_q <= 1'b0;
    end else if (srst_q) begin
      lsb_q  <= 1'b0;
      srst_q <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= wr_i && (wr_addr_i == XFER_ADDR) && wr_data_i[0];
      if (wr_i && wr_addr_i == CFG_ADDR) begin
        lsb_q  <= wr_data_i[6] | wr_data_i[1];
        srst_q <= wr_data_i[5] | wr_data_i[2];
      end
    end
  end

  assign mst_w[0] = cfg0_w;
  assign act_w[0] = cfg0_w;
  assign mst_w[1] = CHIP_ID;
  assign act_w[1] = CHIP_ID;

  for (genvar i = 2; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] m_q;
    logic       hit;
    assign hit = wr_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     m_q <= reg_default(i);
      else if (srst_q) m_q <= reg_default(i);
      else if (hit)    m_q <= wr_data_i;
    end
    assign mst_w[i] = m_q;

    if (is_direct(i)) begin : g_direct
      assign act_w[i] = m_q;
    end else begin : g_shadow
      logic [7:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     s_q <= reg_default(i);
        else if (srst_q) s_q <= reg_default(i);
        else if (xfer_q) s_q <= m_q;
      end
      assign act_w[i] = s_q;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign cfg_o[i*8 +: 8] = act_w[i];
  end

  always_comb begin
    if (rd_addr_i == XFER_ADDR)    rd_data_o = {7'b0, xfer_q};
    else if (rd_addr_i < END_ADDR) rd_data_o = mst_w[rd_addr_i[IDX_W-1:0]];
    else                           rd_data_o = 8'h00;
  end

  assign lsb_o  = lsb_q;
  assign xfer_o = xfer_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/spi_regs_top.sv
module spi_regs_top
  import spi_regs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  csb_i,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic              sclk_s, cs_n_s, sdi_s;
  logic [2:0]        sync_q;
  logic              lsb_w, xfer_w, srst_w, wr_w;
  logic [ADDR_W-1:0] addr_w, wr_addr_w;
  logic [7:0]        wr_data_w, rd_data_w;

  spi_regs_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, csb_i, sdio_i}),
    .q_o   (sync_q)
  );
  assign {sclk_s, cs_n_s, sdi_s} = sync_q;

  spi_regs_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .cs_n_s_i (cs_n_s),
    .sdi_s_i  (sdi_s),
    .lsb_i    (lsb_w),
    .rd_data_i(rd_data_w),
    .addr_o   (addr_w),
    .wr_o     (wr_w),
    .wr_addr_o(wr_addr_w),
    .wr_data_o(wr_data_w),
    .sdo_o    (sdio_o),
    .sdo_oe_o (sdio_oe_o)
  );

  spi_regs_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_w),
    .wr_addr_i(wr_addr_w),
    .wr_data_i(wr_data_w),
    .rd_addr_i(addr_w),
    .rd_data_o(rd_data_w),
    .lsb_o    (lsb_w),
    .xfer_o   (xfer_w),
    .srst_o   (srst_w),
    .cfg_o    (cfg_o)
  );
endmodule

// File: rtl/spi_regs_chk.sv
module spi_regs_chk #(
  parameter int NUM_REGS = 16,
  parameter int SHADOW_IDX = 9,
  parameter int DIRECT_IDX = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sclk_s,
  input logic                  sdio_o,
  input logic                  xfer_w,
  input logic                  srst_w,
  input logic                  wr_w,
  input logic [12:0]           wr_addr_w,
  input logic [7:0]            wr_data_w,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  logic sclk_prev_q, sclk_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s;
  end
  assign sclk_fall = sclk_prev_q & ~sclk_s;

  // R5
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(sdio_o));

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_w && !srst_w) |=> $stable(cfg_o[SHADOW_IDX*8 +: 8]));

  // R8
  direct_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_w && wr_addr_w == 13'(DIRECT_IDX)) |=> (cfg_o[DIRECT_IDX*8 +: 8] == $past(wr_data_w)));

  // R9
  xfer_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_w |=> !xfer_w);

  // R12
  srst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_w |=> !srst_w);
endmodule

bind spi_regs_top spi_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_s   (sclk_s),
  .sdio_o   (sdio_o),
  .xfer_w   (xfer_w),
  .srst_w   (srst_w),
  .wr_w     (wr_w),
  .wr_addr_w(wr_addr_w),
  .wr_data_w(wr_data_w),
  .cfg_o    (cfg_o)
);

// File: tb/spi_regs_top_test.sv
`timescale 1ns/1ps
module spi_regs_top_test;
  localparam int NUM_REGS = 16;
  localparam int HALF = 80;

  typedef struct packed {
    logic [12:0] addr;
    logic [7:0]  wdat;
    logic [7:0]  rexp;
    logic        chk_act;
    logic [7:0]  aexp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{13'h002, 8'hA5, 8'hA5, 1'b1, 8'hA5},
    '{13'h009, 8'h3C, 8'h3C, 1'b1, 8'h01},
    '{13'h001, 8'hFF, 8'h13, 1'b1, 8'h13},
    '{13'h014, 8'h77, 8'h00, 1'b0, 8'h00},
    '{13'h003, 8'h11, 8'h11, 1'b1, 8'h00},
    '{13'h005, 8'hC3, 8'hC3, 1'b1, 8'hC3},
    '{13'h00F, 8'h96, 8'h96, 1'b1, 8'h00},
    '{13'h1FFF, 8'h55, 8'h00, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csb = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  logic [NUM_REGS*8-1:0] cfg;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit oe_seen;

  always #5 clk = ~clk;

  spi_regs_top #(.NUM_REGS(NUM_REGS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csb_i(csb),
    .sdio_i(sdio_in), .sdio_o(sdio_out), .sdio_oe_o(sdio_oe), .cfg_o(cfg)
  );

  function automatic logic [7:0] act(int idx);
    return cfg[idx*8 +: 8];
  endfunction

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic tbit(input logic b, output logic r);
    sdio_in = b;
    #(HALF);
    r = sdio_out;
    if (sdio_oe) oe_seen = 1;
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
  endtask

  task automatic sel();
    csb = 1'b0;
    #(HALF);
  endtask

  task automatic desel();
    csb = 1'b1;
    #(4*HALF);
  endtask

  task automatic send_instr(logic rnw, logic [1:0] w, logic [12:0] a, logic lsb);
    logic [15:0] v;
    logic r;
    v = {rnw, w, a};
    for (int i = 0; i < 16; i++) tbit(lsb ? v[i] : v[15-i], r);
  endtask

  task automatic send_byte(logic [7:0] d, logic lsb);
    logic r;
    for (int i = 0; i < 8; i++) tbit(lsb ? d[i] : d[7-i], r);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic lsb);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tbit(1'b0, r);
      if (lsb) d[i] = r;
      else     d[7-i] = r;
    end
  endtask

  task automatic wr1(logic [12:0] a, logic [7:0] d, logic lsb);
    sel();
    send_instr(1'b0, 2'd0, a, lsb);
    send_byte(d, lsb);
    desel();
  endtask

  task automatic rd1(logic [12:0] a, output logic [7:0] d, input logic lsb);
    sel();
    send_instr(1'b1, 2'd0, a, lsb);
    get_byte(d, lsb);
    desel();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, d3;
    logic r;
    #23 rst_n = 1'b1;
    #(4*HALF);

    // R11 reset state
    chk("R11 cfg0", act(0), 8'h18);
    chk("R11 cfg9", act(9), 8'h01);
    chk("R11 cfg2", act(2), 8'h00);
    chk("R10 id on cfg", act(1), 8'h13);
    chk("R5 oe idle", sdio_oe, 1'b0);
    oe_seen = 0;
    rd1(13'h000, d, 1'b0);
    chk("R11 R1 read cfg0", d, 8'h18);
    chk("R5 oe during read", oe_seen, 1'b1);

    // table: write, read back, active view
    for (int k = 0; k < NV; k++) begin
      wr1(VECS[k].addr, VECS[k].wdat, 1'b0);
      rd1(VECS[k].addr, d, 1'b0);
      chk("R8 R10 R13 readback", d, VECS[k].rexp);
      if (VECS[k].chk_act) chk("R8 active view", act(int'(VECS[k].addr[3:0])), VECS[k].aexp);
    end

    // R9 transfer
    wr1(13'h0FF, 8'h01, 1'b0);
    chk("R9 shadow 9", act(9), 8'h3C);
    chk("R9 shadow 3", act(3), 8'h11);
    chk("R9 shadow 15", act(15), 8'h96);
    rd1(13'h0FF, d, 1'b0);
    chk("R9 self clear", d, 8'h00);

    // R2 three bytes, descending, then new instruction in same frame
    sel();
    send_instr(1'b0, 2'd2, 13'h00E, 1'b0);
    send_byte(8'h21, 1'b0);
    send_byte(8'h22, 1'b0);
    send_byte(8'h23, 1'b0);
    send_instr(1'b1, 2'd0, 13'h00D, 1'b0);
    get_byte(d, 1'b0);
    desel();
    chk("R2 in-frame second instruction", d, 8'h22);
    chk("R8 shadow untouched", act(13), 8'h00);
    sel();
    send_instr(1'b1, 2'd2, 13'h00E, 1'b0);
    get_byte(d, 1'b0);
    get_byte(d2, 1'b0);
    get_byte(d3, 1'b0);
    desel();
    chk("R4 R2 byte0", d, 8'h21);
    chk("R4 R2 byte1", d2, 8'h22);
    chk("R4 R2 byte2", d3, 8'h23);

    // R3 streaming write 7..4
    sel();
    send_instr(1'b0, 2'd3, 13'h007, 1'b0);
    send_byte(8'h31, 1'b0);
    send_byte(8'h32, 1'b0);
    send_byte(8'h33, 1'b0);
    send_byte(8'h34, 1'b0);
    desel();
    chk("R3 stream direct 5", act(5), 8'h33);
    chk("R3 stream direct 4", act(4), 8'h34);
    sel();
    send_instr(1'b1, 2'd3, 13'h007, 1'b0);
    get_byte(d, 1'b0);
    get_byte(d2, 1'b0);
    desel();
    chk("R3 stream read 7", d, 8'h31);
    chk("R3 R4 stream read 6", d2, 8'h32);

    // R6 abort mid-byte
    sel();
    send_instr(1'b0, 2'd0, 13'h002, 1'b0);
    for (int i = 0; i < 4; i++) tbit(1'b1, r);
    desel();
    chk("R6 partial byte dropped", act(2), 8'hA5);
    rd1(13'h002, d, 1'b0);
    chk("R6 fresh instruction after abort", d, 8'hA5);

    // R6 abort mid-instruction
    sel();
    for (int i = 0; i < 8; i++) tbit(1'b1, r);
    desel();
    rd1(13'h009, d, 1'b0);
    chk("R6 partial instruction dropped", d, 8'h3C);

    // R7 pause between bytes
    sel();
    send_instr(1'b0, 2'd1, 13'h00B, 1'b0);
    send_byte(8'h44, 1'b0);
    desel();
    sel();
    send_byte(8'h45, 1'b0);
    desel();
    sel();
    send_instr(1'b1, 2'd1, 13'h00B, 1'b0);
    get_byte(d, 1'b0);
    get_byte(d2, 1'b0);
    desel();
    chk("R7 pause byte0", d, 8'h44);
    chk("R7 pause byte1", d2, 8'h45);

    // R7 clock edge coinciding with select rise
    sel();
    send_instr(1'b0, 2'd3, 13'h002, 1'b0);
    for (int i = 7; i > 0; i--) tbit((8'h5E >> i) & 1'b1, r);
    sdio_in = 1'b0;
    #(HALF);
    sclk = 1'b1;
    csb = 1'b1;
    #(HALF);
    sclk = 1'b0;
    #(4*HALF);
    chk("R7 coincident edge completes byte", act(2), 8'h5E);

    // R3 stream cut inside second byte
    sel();
    send_instr(1'b0, 2'd3, 13'h004, 1'b0);
    send_byte(8'h6F, 1'b0);
    for (int i = 0; i < 3; i++) tbit(1'b1, r);
    desel();
    chk("R3 stream first byte", act(4), 8'h6F);
    rd1(13'h003, d, 1'b0);
    chk("R6 cut byte not written", d, 8'h11);

    // R12 LSB-first mode
    wr1(13'h000, 8'h42, 1'b0);
    chk("R12 cfg0 mirrors", act(0), 8'h5A);
    rd1(13'h000, d, 1'b1);
    chk("R12 lsb read cfg0", d, 8'h5A);
    sel();
    send_instr(1'b0, 2'd3, 13'h00A, 1'b1);
    send_byte(8'h81, 1'b1);
    send_byte(8'h82, 1'b1);
    desel();
    sel();
    send_instr(1'b1, 2'd1, 13'h00A, 1'b1);
    get_byte(d, 1'b1);
    get_byte(d2, 1'b1);
    desel();
    chk("R4 lsb ascending 0A", d, 8'h81);
    chk("R4 lsb ascending 0B", d2, 8'h82);

    // R12 soft reset
    wr1(13'h000, 8'h24, 1'b1);
    chk("R12 soft reset cfg0", act(0), 8'h18);
    chk("R12 soft reset direct", act(2), 8'h00);
    chk("R12 soft reset shadow", act(9), 8'h01);
    chk("R12 soft reset direct 4", act(4), 8'h00);
    rd1(13'h000, d, 1'b0);
    chk("R12 msb order restored", d, 8'h18);
    rd1(13'h00A, d, 1'b0);
    chk("R12 master cleared", d, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule